// File: doc/BRIEF.md
# Serial ROM Stream-Out Engine

This block keeps a 128-byte table and plays it out without pause over one open-drain data wire. A separate, slow stream clock sets the pace, and the block runs on a faster system clock. The system clock first passes the stream clock through a synchronizer and then finds its rising edges. Each rising edge that arrives while the block is enabled moves the output one bit-slot forward. A byte takes nine slots: the eight data bits, most significant first, then a null slot in which the wire is released. After location 127 the pointer returns to location 0 with no gap.

After reset the engine stays quiet for a fixed warm-up of nine stream-clock edges and keeps the wire released during that time. A mode controller elsewhere in the chip drives the enable input. It holds enable high only while the two-wire bus clock stays idle high. A restart pulse from the same controller sends the pointer back to the first bit of location 0 and does not repeat the warm-up. The write port loads the table. In the full chip, the command side of the table owns that port.

Top module: `serial_rom_streamer`

## Requirements
- R1: The table holds 128 bytes at addresses 0 to 127. A write through the load port (`load_we` high at a system clock edge) stores `load_data` at `load_addr`, and that value is what the stream later sends for that address.
- R2: After reset, the wire stays released (`line_low`=0) through the first nine enabled rising edges of the stream clock.
- R3: The tenth enabled rising edge after reset drives bit 7 of location 0.
- R4: Each later enabled rising edge sends the next lower bit of the current byte, from bit 7 down to bit 0. A 0 bit asserts `line_low`. A 1 bit releases the wire.
- R5: The ninth slot of every byte is a null slot. In it the wire is released, so the pull-up makes it read high.
- R6: The null slot of location 127 is followed directly by bit 7 of location 0.
- R7: While `enable` is low, the wire is released one system clock after the edge that samples it. Stream-clock edges are ignored, and the stream position is held until enable returns.
- R8: A `restart` pulse releases the wire and sets the position to bit 7 of location 0. The next enabled rising edge drives that bit, and no warm-up takes place.
- R9: `line_free` is always the complement of `line_low`. The pair never asks to drive and release at the same time.
- R10: The stream clock is sampled through a two-stage synchronizer. One rising edge moves the stream exactly one slot, however long the clock then stays high. The output settles within four system clocks of the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strm_clk | input | 1 | Asynchronous stream clock; each rising edge moves the stream one slot |
| enable | input | 1 | Enable from the mode controller; low stops and releases the stream |
| restart | input | 1 | One-cycle pulse that moves the position back to bit 7 of location 0 |
| load_we | input | 1 | Write strobe for the table |
| load_addr | input | 7 | Table address to write |
| load_data | input | 8 | Byte to write |
| line_low | output | 1 | High when the data wire must be pulled low |
| line_free | output | 1 | High when the data wire is released |

## Verification
The hardest case to reach is the return from location 127 to location 0. It only appears after more than eleven hundred slots, and only if no restart happens before then. The bench therefore streams a directed pass over the whole table first, with known marker bytes at both ends, before any random restarts begin. The bench also waits for a slot that actually pulls the wire low before it drops enable or pulses restart, so that a failure to release the wire would be seen.

// File: rtl/sros_pkg.sv
package sros_pkg;
   // Two phases of the engine: warm-up after reset, then streaming.
   typedef enum logic {
      PH_WAKE = 1'b0,
      PH_RUN  = 1'b1
   } sros_phase_e;
endpackage

// File: rtl/sros_edge_sync.sv
module sros_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   // Synchronizer stages plus one extra flop to detect the edge.
   logic [STAGES:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("sros_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_in};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // A single rising edge gives a single pulse.
   assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/sros_array.sv
module sros_array #(
   parameter int AW = 7,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   initial begin
      assert (DEPTH <= 4096) else $error("sros_array: table too large");
   end

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/sros_seq.sv
module sros_seq
   import sros_pkg::*;
#(
   parameter int AW          = 7,
   parameter int DW          = 8,
   parameter int INIT_CYCLES = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   input  logic          enable,
   input  logic          restart,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          drive_low
);
   localparam int SLOT_W = $clog2(DW + 1);
   localparam int BIT_W  = $clog2(DW);
   localparam int CNT_W  = $clog2(INIT_CYCLES + 1);
   localparam logic [SLOT_W-1:0] NULL_SLOT = SLOT_W'(DW);

   initial begin
      assert (DW >= 2 && (1 << BIT_W) == DW) else $error("sros_seq: DW must be a power of two");
      assert (INIT_CYCLES >= 1) else $error("sros_seq: INIT_CYCLES must be at least 1");
   end

   sros_phase_e       phase;
   logic [CNT_W-1:0]  wake_cnt;
   logic [AW-1:0]     addr;
   logic [SLOT_W-1:0] slot;
   logic              drive_q;
   logic [BIT_W-1:0]  bit_pos;
   logic              cur_bit;

   // Slot 0 is the MSB; slot DW-1 is the LSB.
   assign bit_pos = BIT_W'(DW - 1) - slot[BIT_W-1:0];
   assign cur_bit = rd_data[bit_pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_WAKE;
         wake_cnt <= '0;
         addr     <= '0;
         slot     <= '0;
         drive_q  <= 1'b0;
      end else if (restart) begin
         phase   <= PH_RUN;
         addr    <= '0;
         slot    <= '0;
         drive_q <= 1'b0;
      end else if (!enable) begin
         drive_q <= 1'b0;
      end else if (rise) begin
         if (phase == PH_WAKE) begin
            drive_q <= 1'b0;
            if (wake_cnt == CNT_W'(INIT_CYCLES - 1)) phase <= PH_RUN;
            wake_cnt <= wake_cnt + CNT_W'(1);
         end else if (slot == NULL_SLOT) begin
            drive_q <= 1'b0;
            slot    <= '0;
            addr    <= addr + AW'(1);
         end else begin
            drive_q <= ~cur_bit;
            slot    <= slot + SLOT_W'(1);
         end
      end
   end

   assign rd_addr   = addr;
   assign drive_low = drive_q;

   assert_wake_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAKE) |-> !drive_q);

   assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= NULL_SLOT);

   assert_null_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && enable && !restart && phase == PH_RUN && slot == NULL_SLOT) |=> !drive_q);

   assert_byte_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && enable && !restart && phase == PH_RUN && slot == NULL_SLOT)
         |=> (addr == AW'($past(addr) + 1)) && (slot == '0));

   assert_off_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !drive_q);

   assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !restart) |=> ($stable(addr) && $stable(slot)));

   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (addr == '0 && slot == '0 && !drive_q && phase == PH_RUN));
endmodule

// File: rtl/serial_rom_streamer.sv
module serial_rom_streamer #(
   parameter int AW          = 7,
   parameter int DW          = 8,
   parameter int INIT_CYCLES = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strm_clk,
   input  logic          enable,
   input  logic          restart,
   input  logic          load_we,
   input  logic [AW-1:0] load_addr,
   input  logic [DW-1:0] load_data,
   output logic          line_low,
   output logic          line_free
);
   logic          strm_rise;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;
   logic          drive;

   sros_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (strm_clk),
      .rise     (strm_rise)
   );

   sros_array #(.AW(AW), .DW(DW)) u_array (
      .clk   (clk),
      .we    (load_we),
      .waddr (load_addr),
      .wdata (load_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   sros_seq #(.AW(AW), .DW(DW), .INIT_CYCLES(INIT_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (strm_rise),
      .enable    (enable),
      .restart   (restart),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .drive_low (drive)
   );

   assign line_low  = drive;
   assign line_free = ~drive;
endmodule

// File: tb/tb_serial_rom_streamer.sv
`timescale 1ns/1ps
module tb_serial_rom_streamer;
   localparam int AW    = 7;
   localparam int DW    = 8;
   localparam int DEPTH = 128;
   localparam int INIT  = 9;

   logic clk = 1'b0, rst_n = 1'b0, strm_clk = 1'b0, enable = 1'b0, restart = 1'b0;
   logic load_we = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [DW-1:0] load_data = '0;
   logic line_low, line_free;

   always #2.5 clk = ~clk;

   serial_rom_streamer dut (
      .clk(clk), .rst_n(rst_n), .strm_clk(strm_clk), .enable(enable), .restart(restart),
      .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
      .line_low(line_low), .line_free(line_free)
   );

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] m_mem [DEPTH];
   bit m_run = 0, m_first = 0, m_after_rst = 0, m_wrapped = 0;
   int m_cnt = 0, m_addr = 0, m_slot = 0;

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: line_low actual=%0d expected=%0d (addr %0d slot %0d)", req, act, exp, m_addr, m_slot);
      end
   endtask

   // Expected drive for the next enabled edge, computed from the requirements.
   function automatic bit exp_drive(int a, int s);
      if (s >= DW) return 1'b0;
      return !m_mem[a][DW-1-s];
   endfunction

   task automatic load(int a, int d);
      @(negedge clk);
      load_we = 1'b1; load_addr = AW'(a); load_data = DW'(d);
      @(negedge clk);
      load_we = 1'b0;
      m_mem[a] = DW'(d);
   endtask

   task automatic do_restart();
      @(negedge clk) restart = 1'b1;
      @(negedge clk) restart = 1'b0;
      @(negedge clk);
      check(line_low == 1'b0 && line_free == 1'b1, "R8", int'(line_low), 0);
      m_addr = 0; m_slot = 0; m_run = 1; m_after_rst = 1;
   endtask

   task automatic step_edge(bit en, int hi, string force_tag);
      bit e;
      string tag;
      @(negedge clk);
      enable = en; strm_clk = 1'b1;
      repeat (hi) @(negedge clk);
      e = 1'b0;
      if (!en) tag = "R7";
      else if (!m_run) begin
         tag = "R2";
         m_cnt++;
         if (m_cnt == INIT) begin m_run = 1; m_first = 1; end
      end else if (m_slot == DW) begin
         tag = "R5";
         m_slot = 0;
         if (m_addr == DEPTH - 1) begin m_addr = 0; m_wrapped = 1; end
         else m_addr++;
      end else begin
         e = exp_drive(m_addr, m_slot);
         if (m_first) tag = "R3";
         else if (m_after_rst) tag = "R8";
         else if (m_wrapped && m_addr == 0) tag = "R6";
         else tag = "R4";
         m_first = 0; m_after_rst = 0;
         m_slot++;
         if (m_slot == DW) m_wrapped = 0;
      end
      if (force_tag != "") tag = force_tag;
      check(line_low == e && line_free == !e, tag, int'(line_low), int'(e));
      @(negedge clk) strm_clk = 1'b0;
      repeat (7) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // Reset state: wire released, pair complementary.
      check(line_low == 1'b0, "R2", int'(line_low), 0);
      check(line_free == ~line_low, "R9", int'(line_free), int'(~line_low));
      rst_n = 1'b1;
      // Fill the table: markers at both ends, random elsewhere.
      for (int a = 0; a < DEPTH; a++) begin
         int d;
         d = int'($urandom % 256);
         if (a == 0) d = 8'hA5;
         if (a == 1) d = 8'h00;
         if (a == 2) d = 8'hFF;
         if (a == DEPTH - 1) d = 8'h3C;
         load(a, d);
      end
      // Warm-up plus full pass with wraparound, one long-high edge for R10.
      for (int i = 0; i < INIT + (DEPTH + 2) * (DW + 1); i++)
         step_edge(1'b1, (i == INIT + 20) ? 40 : 8, (i == INIT + 20) ? "R10" : "");
      step_edge(1'b1, 8, "");
      // Drop enable while the wire is pulled low.
      for (int g = 0; g < 40 && !(line_low == 1'b1); g++) step_edge(1'b1, 8, "");
      @(negedge clk) enable = 1'b0;
      repeat (2) @(negedge clk);
      check(line_low == 1'b0 && line_free == 1'b1, "R7", int'(line_low), 0);
      for (int i = 0; i < 5; i++) step_edge(1'b0, 8, "");
      for (int i = 0; i < 12; i++) step_edge(1'b1, 8, "");
      // Restart with the wire pulled low.
      for (int g = 0; g < 40 && !(line_low == 1'b1); g++) step_edge(1'b1, 8, "");
      do_restart();
      for (int i = 0; i < 2 * (DW + 1); i++) step_edge(1'b1, 8, "");
      // Rewrite location 0 and stream it again.
      load(0, 8'h5A);
      do_restart();
      for (int i = 0; i < DW; i++) step_edge(1'b1, 8, "R1");
      // Random mix of enable, restarts and table writes.
      for (int i = 0; i < 400; i++) begin
         if ($urandom % 40 == 0) do_restart();
         if ($urandom % 10 == 0) load(int'($urandom % DEPTH), int'($urandom % 256));
         step_edge(($urandom % 4) != 0, 8, "");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule